// File: doc/BRIEF.md
# Descriptor-Chained SPI Transfer Sequencer

This block drives an external serial shifter through a linked chain of transfer descriptors kept in a small register file. Each descriptor gives the lane width, what to transmit (data, all zeros, all ones, or nothing), whether receive is on, the size of one unit, how many units to move, whether chip select is dropped when the descriptor ends, the index of the following descriptor, and a flag that marks the end of the chain.

Software fills the descriptors, sets the mode-enable bit and the first index, and pulses start. The sequencer then requests one unit at a time from the shifter. Each request carries the fields of the current descriptor. When the unit count of a descriptor runs out, the sequencer either jumps to the next descriptor or finishes the chain. A descriptor that cannot run raises a programming error. A stop request ends the chain at the next unit boundary. The sequencer passes a FIFO-clear request through as a one-cycle pulse.

Top module: `spi_chain_seq`

## Requirements
- R1: After reset, cs_n is 1, busy, done, prog_err, sh_req and fifo_clr are 0, and cur_idx is 0.
- R2: A start pulse is accepted only when the sequencer is idle and the stored mode enable is 1. In any other case the start pulse has no effect.
- R3: While sh_req is 1, the shifter outputs carry the fields of the current descriptor. The descriptor word is laid out as width [1:0] (0 single, 1 dual, 2 quad), tx [3:2] (0 off, 1 FIFO data, 2 zeros, 3 ones), rx [4], close [5], unit [7:6], next [11:8], last [12] and count [27:13]. sh_bits gives the unit size in bits: 1, 8, 32 or 128 for unit codes 0 to 3. A unit is done on each clock edge where sh_req and sh_ack are both 1.
- R4: A descriptor moves exactly count units (1 to 32767). The sequencer then continues with the descriptor named by its next field. cur_idx shows the descriptor that is executing.
- R5: When a descriptor with close=1 ends, cs_n goes to 1 before the next descriptor starts. When a descriptor with close=0 ends, cs_n stays 0 into the next descriptor.
- R6: When a descriptor with last=1 ends, done goes to 1, cs_n goes to 1 and the sequencer returns to idle.
- R7: A descriptor with count 0 or width 3 sets prog_err, sets cs_n to 1, ends the chain and moves no unit.
- R8: A stop pulse during a chain lets the unit in progress complete, then sets cs_n to 1 and returns to idle without setting done.
- R9: clr_done clears done and clr_err clears prog_err. Each clear acts on its own flag only.
- R10: A cmd_flush pulse gives exactly one fifo_clr pulse on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dsc_we | input | 1 | Descriptor write strobe |
| dsc_addr | input | 4 | Descriptor index to write |
| dsc_wdata | input | 28 | Descriptor word |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_mode_en | input | 1 | Descriptor mode enable (stored on ctrl_we) |
| ctrl_first | input | 4 | First descriptor index (stored on ctrl_we) |
| cmd_start | input | 1 | Start pulse |
| cmd_stop | input | 1 | Stop pulse |
| cmd_flush | input | 1 | FIFO clear request pulse |
| clr_done | input | 1 | Write-one clear of done |
| clr_err | input | 1 | Write-one clear of prog_err |
| sh_ack | input | 1 | Shifter finished the requested unit |
| sh_req | output | 1 | Unit request to the shifter |
| sh_width | output | 2 | Lane width of the request |
| sh_tx | output | 2 | Transmit source of the request |
| sh_rx | output | 1 | Receive enable of the request |
| sh_bits | output | 8 | Bits per unit |
| cs_n | output | 1 | Chip select, active low |
| fifo_clr | output | 1 | FIFO clear pulse |
| busy | output | 1 | Chain in progress |
| done | output | 1 | Chain completed flag |
| prog_err | output | 1 | Programming error flag |
| cur_idx | output | 4 | Descriptor index in use |

## Verification
A wrong unit counter or a wrong next-index register shows at the ports as the wrong number of request/acknowledge handshakes, or as a wrong sh_bits total over a chain. It is also visible in cur_idx the cycle after a descriptor ends. A chip-select state that does not match the close flags shows as an extra or missing rising edge on cs_n, within one cycle of the boundary. A stop that is not held until the next boundary shows as a unit count that differs by one, and as done being set when it should stay clear.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int IDX_W  = 4;
  localparam int NDESC  = 1 << IDX_W;
  localparam int CNT_W  = 15;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             last;
    logic [IDX_W-1:0] nxt;
    logic [1:0]       unit;
    logic             close;
    logic             rx;
    logic [1:0]       tx;
    logic [1:0]       width;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN} seq_st_t;

  function automatic logic [7:0] unit_bits(input logic [1:0] code);
    case (code)
      2'd0:    unit_bits = 8'd1;
      2'd1:    unit_bits = 8'd8;
      2'd2:    unit_bits = 8'd32;
      default: unit_bits = 8'd128;
    endcase
  endfunction

  function automatic logic desc_bad(input desc_t d);
    desc_bad = (d.cnt == '0) || (d.width == 2'd3);
  endfunction
endpackage

// File: rtl/spi_chain_dfile.sv
module spi_chain_dfile
  import spi_chain_pkg::*;
#(
  parameter int N = NDESC,
  parameter int AW = IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DESC_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output desc_t             rdata
);
  logic [DESC_W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              regs[g] <= '0;
      else if (we && waddr == AW'(g))          regs[g] <= wdata;
    end
  end

  assign rdata = desc_t'(regs[raddr]);
endmodule

// File: rtl/spi_chain_ucnt.sv
module spi_chain_ucnt
  import spi_chain_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  input  logic         active,
  output logic         last_unit
);
  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain <= '0;
    else if (load)   remain <= load_val;
    else if (dec)    remain <= remain - 1'b1;
  end

  assign last_unit = (remain == W'(1));

  // R4: a running descriptor always has units left
  a_r4_units_left: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (remain != '0));
endmodule

// File: rtl/spi_chain_seq.sv
module spi_chain_seq
  import spi_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsc_we,
  input  logic [IDX_W-1:0]  dsc_addr,
  input  logic [DESC_W-1:0] dsc_wdata,
  input  logic              ctrl_we,
  input  logic              ctrl_mode_en,
  input  logic [IDX_W-1:0]  ctrl_first,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_flush,
  input  logic              clr_done,
  input  logic              clr_err,
  input  logic              sh_ack,
  output logic              sh_req,
  output logic [1:0]        sh_width,
  output logic [1:0]        sh_tx,
  output logic              sh_rx,
  output logic [7:0]        sh_bits,
  output logic              cs_n,
  output logic              fifo_clr,
  output logic              busy,
  output logic              done,
  output logic              prog_err,
  output logic [IDX_W-1:0]  cur_idx
);
  seq_st_t          st;
  logic [IDX_W-1:0] idx, first_idx;
  logic             mode_en, stop_pend;
  desc_t            cur;
  logic             last_unit;

  // named internal events
  logic unit_done, bad_load, good_load, abort_now;
  assign unit_done = (st == S_RUN) && sh_ack;
  assign bad_load  = (st == S_LOAD) && desc_bad(cur);
  assign good_load = (st == S_LOAD) && !desc_bad(cur);
  assign abort_now = stop_pend || cmd_stop;

  spi_chain_dfile u_dfile (
    .clk(clk), .rst_n(rst_n), .we(dsc_we), .waddr(dsc_addr),
    .wdata(dsc_wdata), .raddr(idx), .rdata(cur)
  );

  spi_chain_ucnt u_cnt (
    .clk(clk), .rst_n(rst_n), .load(good_load), .load_val(cur.cnt),
    .dec(unit_done), .active(st == S_RUN), .last_unit(last_unit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      first_idx <= '0;
      mode_en   <= 1'b0;
      stop_pend <= 1'b0;
      cs_n      <= 1'b1;
      done      <= 1'b0;
      prog_err  <= 1'b0;
      fifo_clr  <= 1'b0;
    end else begin
      fifo_clr <= cmd_flush;
      if (ctrl_we) begin
        mode_en   <= ctrl_mode_en;
        first_idx <= ctrl_first;
      end
      if (clr_done) done     <= 1'b0;
      if (clr_err)  prog_err <= 1'b0;
      if (cmd_stop && st != S_IDLE) stop_pend <= 1'b1;
      case (st)
        S_IDLE: begin
          stop_pend <= 1'b0;
          if (cmd_start && mode_en) begin
            idx <= first_idx;
            st  <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (bad_load) begin
            prog_err <= 1'b1;
            cs_n     <= 1'b1;
            st       <= S_IDLE;
          end else begin
            cs_n <= 1'b0;
            st   <= S_RUN;
          end
        end
        S_RUN: begin
          if (unit_done) begin
            if (abort_now) begin
              cs_n <= 1'b1;
              st   <= S_IDLE;
            end else if (last_unit) begin
              if (cur.last) begin
                done <= 1'b1;
                cs_n <= 1'b1;
                st   <= S_IDLE;
              end else begin
                if (cur.close) cs_n <= 1'b1;
                idx <= cur.nxt;
                st  <= S_LOAD;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sh_req   = (st == S_RUN);
  assign sh_width = cur.width;
  assign sh_tx    = cur.tx;
  assign sh_rx    = cur.rx;
  assign sh_bits  = unit_bits(cur.unit);
  assign busy     = (st != S_IDLE);
  assign cur_idx  = idx;

  // R1: chip select is released whenever idle
  a_r1_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> cs_n);
  // R3: a unit request only occurs with chip select asserted
  a_r3_req_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sh_req |-> !cs_n);
  // R6: done rises only together with release and idle
  a_r6_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cs_n && st == S_IDLE));
  // R7: a programming error comes only from a descriptor load
  a_r7_err_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_err) |-> ($past(st) == S_LOAD && cs_n));
  // R8: a pending stop ends the chain at the unit boundary
  a_r8_stop_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && stop_pend && sh_ack) |=> (st == S_IDLE && cs_n && !$rose(done)));
endmodule

// File: tb/sim_spi_chain_seq.sv
module sim_spi_chain_seq;
  import spi_chain_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, dsc_we, ctrl_we, ctrl_mode_en, cmd_start, cmd_stop, cmd_flush;
  logic clr_done, clr_err, sh_ack, ack_en;
  logic [3:0] dsc_addr, ctrl_first, cur_idx;
  logic [27:0] dsc_wdata;
  logic sh_req, sh_rx, cs_n, fifo_clr, busy, done, prog_err;
  logic [1:0] sh_width, sh_tx;
  logic [7:0] sh_bits;

  spi_chain_seq u0 (.*);

  int compared = 0, mismatched = 0, cycles = 0;
  int units = 0, bitsum = 0, rises = 0;
  logic cs_prev = 1'b1;

  always @(negedge clk) sh_ack <= ack_en && sh_req;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (sh_req && sh_ack) begin
      units  <= units + 1;
      bitsum <= bitsum + int'(sh_bits);
    end
    if (cs_n && !cs_prev) rises <= rises + 1;
    cs_prev <= cs_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [27:0] mk(input int w, input int tx, input int rx,
      input int cl, input int un, input int nx, input int ls, input int cn);
    mk = {cn[14:0], ls[0], nx[3:0], un[1:0], cl[0], rx[0], tx[1:0], w[1:0]};
  endfunction

  task automatic wr_desc(input int a, input logic [27:0] v);
    @(negedge clk); dsc_we = 1; dsc_addr = a[3:0]; dsc_wdata = v;
    @(negedge clk); dsc_we = 0;
  endtask

  task automatic wr_ctrl(input logic en, input int f);
    @(negedge clk); ctrl_we = 1; ctrl_mode_en = en; ctrl_first = f[3:0];
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr_done = 1; clr_err = 1;
    @(negedge clk); clr_done = 0; clr_err = 0;
    units = 0; bitsum = 0; rises = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); cmd_start = 1;
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 2000 && busy; g++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_ack(input logic v);
    @(posedge clk); #1 ack_en = v;
  endtask

  typedef struct packed {
    logic [3:0]  first;
    logic [7:0]  n_units;
    logic [15:0] n_bits;
    logic        exp_done;
    logic        exp_err;
    logic [3:0]  n_rises;
    logic [3:0]  fin_idx;
  } vec_t;

  // R4 R5 R6 R7 chains
  localparam vec_t VEC [5] = '{
    '{4'd0, 8'd6, 16'd154, 1'b1, 1'b0, 4'd2, 4'd2},
    '{4'd5, 8'd4, 16'd128, 1'b1, 1'b0, 4'd1, 4'd5},
    '{4'd3, 8'd0, 16'd0,   1'b0, 1'b1, 4'd0, 4'd3},
    '{4'd4, 8'd0, 16'd0,   1'b0, 1'b1, 4'd0, 4'd4},
    '{4'd6, 8'd2, 16'd16,  1'b0, 1'b1, 4'd1, 4'd3}
  };

  initial begin
    #(10 * 100000);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 0; dsc_we = 0; ctrl_we = 0; ctrl_mode_en = 0; cmd_start = 0;
    cmd_stop = 0; cmd_flush = 0; clr_done = 0; clr_err = 0; ack_en = 0;
    dsc_addr = 0; ctrl_first = 0; dsc_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", cs_n, 1);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 prog_err", prog_err, 0);
    chk("R1 sh_req", sh_req, 0);
    chk("R1 cur_idx", cur_idx, 0);
    chk("R1 fifo_clr", fifo_clr, 0);

    wr_desc(0, mk(1, 1, 1, 0, 1, 1, 0, 3));
    wr_desc(1, mk(0, 2, 0, 1, 0, 2, 0, 2));
    wr_desc(2, mk(2, 3, 0, 0, 3, 0, 1, 1));
    wr_desc(3, mk(0, 1, 0, 0, 0, 0, 0, 0));
    wr_desc(4, mk(3, 1, 0, 0, 0, 0, 1, 5));
    wr_desc(5, mk(0, 1, 1, 0, 2, 0, 1, 4));
    wr_desc(6, mk(0, 1, 0, 0, 1, 3, 0, 2));

    // R2: start with mode disabled is ignored
    wr_ctrl(0, 0);
    pulse_start();
    repeat (3) @(negedge clk);
    chk("R2 busy with mode off", busy, 0);
    chk("R2 sh_req with mode off", sh_req, 0);
    chk("R2 cs_n with mode off", cs_n, 1);

    set_ack(1);
    foreach (VEC[i]) begin
      wr_ctrl(1, VEC[i].first);
      clear_all();
      pulse_start();
      wait_idle();
      chk("R4 unit count", units, VEC[i].n_units);
      chk("R3 bit total", bitsum, VEC[i].n_bits);
      chk("R6 done", done, VEC[i].exp_done);
      chk("R7 prog_err", prog_err, VEC[i].exp_err);
      chk("R5 cs_n rises", rises, VEC[i].n_rises);
      chk("R4 final cur_idx", cur_idx, VEC[i].fin_idx);
      chk("R6 cs_n released", cs_n, 1);
    end

    // R9: clears act independently (done=0, err=1 left from last vector)
    wr_ctrl(1, 5);
    @(negedge clk); clr_done = 1; @(negedge clk); clr_done = 0;
    pulse_start(); wait_idle();
    chk("R9 done set", done, 1);
    chk("R9 err kept by clr_done", prog_err, 1);
    @(negedge clk); clr_err = 1; @(negedge clk); clr_err = 0;
    chk("R9 err cleared", prog_err, 0);
    chk("R9 done kept by clr_err", done, 1);
    @(negedge clk); clr_done = 1; @(negedge clk); clr_done = 0;
    chk("R9 done cleared", done, 0);

    // R3: fields while held, R2: start while busy ignored
    set_ack(0);
    wr_ctrl(1, 0);
    clear_all();
    pulse_start();
    repeat (2) @(negedge clk);
    chk("R3 sh_req", sh_req, 1);
    chk("R3 sh_width", sh_width, 1);
    chk("R3 sh_tx", sh_tx, 1);
    chk("R3 sh_rx", sh_rx, 1);
    chk("R3 sh_bits", sh_bits, 8);
    chk("R4 cur_idx", cur_idx, 0);
    wr_ctrl(1, 5);
    pulse_start();
    chk("R2 start while busy keeps idx", cur_idx, 0);
    set_ack(1);
    wait_idle();
    chk("R2 busy start ignored units", units, 6);
    chk("R3 quad width reached", cur_idx, 2);

    // R8: stop mid-descriptor
    set_ack(0);
    wr_ctrl(1, 5);
    clear_all();
    pulse_start();
    repeat (2) @(negedge clk);
    @(negedge clk); cmd_stop = 1; @(negedge clk); cmd_stop = 0;
    repeat (2) @(negedge clk);
    chk("R8 waits for boundary busy", busy, 1);
    chk("R8 waits for boundary cs", cs_n, 0);
    set_ack(1);
    wait_idle();
    chk("R8 units after stop", units, 1);
    chk("R8 no done", done, 0);
    chk("R8 cs released", cs_n, 1);

    // R10: flush pulse
    @(negedge clk); cmd_flush = 1;
    @(negedge clk); cmd_flush = 0;
    chk("R10 fifo_clr high", fifo_clr, 1);
    @(negedge clk);
    chk("R10 fifo_clr one cycle", fifo_clr, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule